// File: doc/BRIEF.md
# Eight-Way Paired Recency Victim Selector

This block chooses which way of an eight-way cache set to replace next. It approximates least-recently-used ordering in two levels. The eight ways are split into four fixed pairs. Each pair holds one bit that names the member touched last. A six-bit triangular matrix holds the exact recency order of the four pairs. Per set, the stored state is ten bits, in place of the 28 bits that exact recency over eight ways would need.

The cache controller pulses an access strobe together with a set index and a way number on every hit and on every fill. In the same clock edge, the block updates that set's pair bit and pair matrix. Hits and fills are treated the same way. A separate query port takes a set index and returns, without a clock, the victim way for that set, computed from the stored state.

Top module: `lru8_pair_sel`

## Requirements
- R1: Reset is synchronous and active high. It clears every set's state. After reset, every set reports victim way 1 (pair 0 is the least recent pair and member 0 is recorded as the most recent member).
- R2: A way number is decoded as follows: bits [2:1] select the pair (ways {0,1}, {2,3}, {4,5}, {6,7}) and bit [0] selects the member within that pair.
- R3: The victim's member bit is the complement of the member of its pair that was accessed last.
- R4: The victim's pair is the pair that has gone longest without any access among the four pairs. Before any access, the pairs rank from least recent to most recent as 0, 1, 2, 3.
- R5: An access sampled at a rising clock edge changes the victim reported for its set right after that edge. The query output is combinational in the query set index.
- R6: While the access strobe is low, no set's state changes, whatever the set and way inputs carry.
- R7: An access to one set leaves the victim of every other set unchanged.
- R8: Directly after an access, the way just accessed is never the victim reported for that set.
- R9: Repeating an access to the way most recently accessed in a set leaves that set's victim unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe (hit or fill) |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 3 | Way number of the access |
| vic_set | input | SET_W | Set index whose victim is queried |
| vic_way | output | 3 | Victim way for the queried set |

## Verification
An access's effect is due one edge after the strobe is sampled. The victim read path adds no further register, so the new victim can be read as soon as the query set is presented after that edge. The bench drives every input on the falling edge. It changes the query set only after the capturing rising edge has passed, and it reads the victim one nanosecond later, well clear of the next rising edge. For reset, the bench likewise reads only after the clearing edge. The checker's temporal properties look exactly one cycle past the strobe or the idle cycle they concern.

// File: rtl/lru8_pkg.sv
package lru8_pkg;

    localparam int WAYS     = 8;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int PAIRS    = WAYS / 2;
    localparam int PAIR_W   = $clog2(PAIRS);
    localparam int MTX_BITS = PAIRS * (PAIRS - 1) / 2;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [PAIR_W-1:0] pair_t;

    // Per-set replacement state.
    // mru[p] : member of pair p touched last.
    // mtx    : bit (i,j), i<j, set means pair i is more recent than pair j.
    typedef struct packed {
        logic [PAIRS-1:0]    mru;
        logic [MTX_BITS-1:0] mtx;
    } set_state_t;

    // Flat position of the matrix bit for pair i above pair j (i < j).
    function automatic int mtx_pos(input int i, input int j);
        return (i * (2 * PAIRS - i - 1)) / 2 + (j - i - 1);
    endfunction

    function automatic pair_t way_pair(input way_t w);
        return w[WAY_W-1:1];
    endfunction

    function automatic logic way_member(input way_t w);
        return w[0];
    endfunction

endpackage

// File: rtl/lru8_state_next.sv
module lru8_state_next
    import lru8_pkg::*;
(
    input  set_state_t cur,
    input  way_t       way,
    output set_state_t nxt
);

    pair_t hit_pair;

    always_comb begin
        hit_pair = way_pair(way);
        nxt      = cur;
        nxt.mru[hit_pair] = way_member(way);
        for (int i = 0; i < PAIRS; i++) begin
            for (int j = i + 1; j < PAIRS; j++) begin
                if (i == int'(hit_pair)) begin
                    nxt.mtx[mtx_pos(i, j)] = 1'b1;   // row of touched pair
                end else if (j == int'(hit_pair)) begin
                    nxt.mtx[mtx_pos(i, j)] = 1'b0;   // column of touched pair
                end
            end
        end
    end

endmodule

// File: rtl/lru8_victim_pick.sv
module lru8_victim_pick
    import lru8_pkg::*;
(
    input  set_state_t st,
    output way_t       victim
);

    logic [PAIRS-1:0] is_oldest;
    pair_t            old_pair;

    always_comb begin
        for (int p = 0; p < PAIRS; p++) begin
            is_oldest[p] = 1'b1;
            for (int j = p + 1; j < PAIRS; j++) begin
                if (st.mtx[mtx_pos(p, j)]) is_oldest[p] = 1'b0;
            end
            for (int k = 0; k < p; k++) begin
                if (!st.mtx[mtx_pos(k, p)]) is_oldest[p] = 1'b0;
            end
        end
    end

    always_comb begin
        old_pair = '0;
        for (int p = PAIRS - 1; p >= 0; p--) begin
            if (is_oldest[p]) old_pair = pair_t'(p);
        end
        victim = {old_pair, ~st.mru[old_pair]};
    end

endmodule

// File: rtl/lru8_state_bank.sv
module lru8_state_bank
    import lru8_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  set_state_t       wr_state,
    input  logic [SET_W-1:0] rd_a_set,
    output set_state_t       rd_a,
    input  logic [SET_W-1:0] rd_b_set,
    output set_state_t       rd_b
);

    set_state_t state_q [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[g] <= '0;
            end else if (wr_en && wr_set == SET_W'(g)) begin
                state_q[g] <= wr_state;
            end
        end
    end

    assign rd_a = state_q[rd_a_set];
    assign rd_b = state_q[rd_b_set];

endmodule

// File: rtl/lru8_pair_sel.sv
module lru8_pair_sel
    import lru8_pkg::*;
#(
    parameter int  SETS  = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic [SET_W-1:0] vic_set,
    output logic [2:0]       vic_way
);

    set_state_t acc_cur;
    set_state_t acc_nxt;
    set_state_t vic_st;
    way_t       vic_pick;

    lru8_state_bank #(.SETS(SETS), .SET_W(SET_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc_valid),
        .wr_set   (acc_set),
        .wr_state (acc_nxt),
        .rd_a_set (acc_set),
        .rd_a     (acc_cur),
        .rd_b_set (vic_set),
        .rd_b     (vic_st)
    );

    lru8_state_next u_next (
        .cur (acc_cur),
        .way (way_t'(acc_way)),
        .nxt (acc_nxt)
    );

    lru8_victim_pick u_pick (
        .st     (vic_st),
        .victim (vic_pick)
    );

    assign vic_way = vic_pick;

endmodule

// File: rtl/lru8_pair_sel_chk.sv
module lru8_pair_sel_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic [2:0]       acc_way,
    input logic [SET_W-1:0] vic_set,
    input logic [2:0]       vic_way
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: first cycle after reset shows victim way 1 for any set
    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            assert_reset_victim_R1: assert (vic_way == 3'd1);
        end
    end

    // R8: the way just accessed is not reported as victim for that set
    assert_not_just_used_R8: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (vic_set != $past(acc_set)) || (vic_way != $past(acc_way)));

    // R6: an idle cycle leaves the queried victim as it was
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (vic_set != $past(vic_set)) || (vic_way == $past(vic_way)));

    // R7: access to a different set leaves the queried victim alone
    assert_set_isolation_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_set != vic_set)
            |=> (vic_set != $past(vic_set)) || (vic_way == $past(vic_way)));

    // R5: victim output is always a defined value out of reset
    assert_defined_victim_R5: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(vic_way));

endmodule

bind lru8_pair_sel lru8_pair_sel_chk #(.SET_W(SET_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .vic_set   (vic_set),
    .vic_way   (vic_way)
);

// File: tb/sim_lru8_pair_sel.sv
module sim_lru8_pair_sel;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SETS  = 16;
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [2:0]       acc_way = '0;
    logic [SET_W-1:0] vic_set = '0;
    logic [2:0]       vic_way;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lru8_pair_sel #(.SETS(SETS)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .vic_set(vic_set), .vic_way(vic_way)
    );

    // Reference model: explicit recency list of pairs (index 0 = most recent)
    int ord [SETS][4];
    int mru [SETS][4];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int p = 0; p < 4; p++) begin
                ord[s][p] = 3 - p;
                mru[s][p] = 0;
            end
        end
    endtask

    task automatic model_touch(input int s, input int w);
        int p, pos;
        p = w / 2;
        mru[s][p] = w % 2;
        pos = 0;
        for (int k = 0; k < 4; k++) if (ord[s][k] == p) pos = k;
        for (int k = pos; k > 0; k--) ord[s][k] = ord[s][k-1];
        ord[s][0] = p;
    endtask

    function automatic int model_victim(input int s);
        return ord[s][3] * 2 + (1 - mru[s][ord[s][3]]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input int s, input int w);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set   = SET_W'(s);
        acc_way   = 3'(w);
        @(negedge clk);
        acc_valid = 1'b0;
        model_touch(s, w);
    endtask

    task automatic read_victim(input int s, output int v);
        vic_set = SET_W'(s);
        #1;
        v = int'(vic_way);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // {way accessed on set 0, expected victim afterwards}
    localparam logic [5:0] TBL [10] = '{
        {3'd1, 3'd3}, {3'd3, 3'd5}, {3'd5, 3'd7}, {3'd6, 3'd0}, {3'd0, 3'd2},
        {3'd2, 3'd4}, {3'd1, 3'd4}, {3'd4, 3'd7}, {3'd7, 3'd3}, {3'd3, 3'd0}
    };

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        model_reset();
        do_reset();

        // R1: reset victim on every set
        for (int s = 0; s < SETS; s++) begin
            read_victim(s, v);
            chk("R1 reset victim", v, 1);
        end

        // R2 R3 R4 R5: table walk on set 0
        for (int i = 0; i < 10; i++) begin
            access(0, int'(TBL[i][5:3]));
            read_victim(0, v);
            chk("R2 R3 R4 R5 table", v, int'(TBL[i][2:0]));
            chk("R8 table", int'(v == int'(TBL[i][5:3])), 0);
        end

        // R6: strobe low, other inputs moving
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            acc_set = SET_W'(i % 2);
            acc_way = 3'(i + 1);
        end
        @(negedge clk);
        read_victim(0, v);
        chk("R6 idle", v, 0);
        read_victim(1, v);
        chk("R6 idle other set", v, 1);

        // R7: access set 5 must leave set 0 alone
        access(5, 0);
        read_victim(0, v);
        chk("R7 isolation", v, 0);
        read_victim(5, v);
        chk("R7 accessed set", v, 3);

        // R9: repeat of last way on set 0
        access(0, 3);
        read_victim(0, v);
        chk("R9 repeat", v, 0);
        access(0, 3);
        read_victim(0, v);
        chk("R9 repeat twice", v, 0);

        // R4 R8: long pseudo-random stream against the model
        for (int i = 0; i < 400; i++) begin
            int s, w;
            s = int'($urandom % 4);
            w = int'($urandom % 8);
            access(s, w);
            read_victim(s, v);
            chk("R4 stream", v, model_victim(s));
            chk("R8 stream", int'(v == w), 0);
            if (i % 50 == 0) begin
                read_victim((s + 1) % 4, v);
                chk("R7 stream", v, model_victim((s + 1) % 4));
            end
        end

        // R1: reset in mid-run
        do_reset();
        read_victim(0, v);
        chk("R1 mid reset", v, 1);
        read_victim(5, v);
        chk("R1 mid reset", v, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule